// File: doc/BRIEF.md
# Accelerometer Offset Calibration Engine

This block works out the three 8-bit offset trim values for a three-axis accelerometer. The sensor must rest in one known pose during the run: X and Y at 0 g and Z at +1 g. A start pulse arms the engine. It then waits a settling interval, during which any incoming samples are thrown away. Next it accumulates a fixed number of three-axis samples from a sample stream that is qualified by a valid strobe. It divides each axis sum by the sample count to get a mean, and turns each mean into a trim value. The trim has the opposite sign to the error, is taken at a quarter of the sample scale and is clamped to the 8-bit range. On Z the 1 g reading is removed first.

The engine then writes the three trims to the sensor's offset registers. It does this through a request/acknowledge handshake with an external bus controller, one register at a time, and ends with a one-cycle completion pulse. The computed trims also stay visible on dedicated outputs until the next run.

Top module: `acal_engine`

## Requirements
- R1: After reset `busy`, `wr_req` and `done` are low and `ofs_x`, `ofs_y`, `ofs_z` are zero.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle. For the first `SETTLE_CYCLES` cycles of the run, every asserted `smp_valid` is discarded.
- R3: After settling, the engine adds up exactly `NUM_SAMPLES` valid samples per axis, with samples read as `SAMPLE_W`-bit two's complement. Each mean is the sum divided by `NUM_SAMPLES`, rounded toward zero.
- R4: The X and Y trims are the negated quotient of the axis mean divided by 4, rounded toward zero. For example, a mean of -5 gives +1 and a mean of -3 gives 0.
- R5: The Z trim is the negated quotient of (Z mean - `Z_BIAS`) divided by 4, rounded toward zero. With the default bias of 345, a Z mean of 0 gives +86.
- R6: Each trim is clamped to -128..+127 and driven as an 8-bit two's-complement value (0x80 and 0x7F at the limits).
- R7: Three writes are issued in a fixed order: X trim to `ADDR_X` (default 0x1E), then Y to `ADDR_Y` (0x1F), then Z to `ADDR_Z` (0x20).
- R8: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` stay unchanged. The cycle after an acknowledge, `wr_req` is low. The next write begins only after that.
- R9: A `start` pulse that arrives during a run does not alter the run, its results or its write count, and it does not launch a new run.
- R10: `done` is high for exactly one cycle, the cycle after the third acknowledge is sampled. `busy` is low on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (ignored while busy) |
| smp_valid | input | 1 | One three-axis sample is present this cycle |
| smp_x | input | SAMPLE_W | X sample, two's complement |
| smp_y | input | SAMPLE_W | Y sample, two's complement |
| smp_z | input | SAMPLE_W | Z sample, two's complement |
| wr_ack | input | 1 | Bus controller has accepted the current write |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 8 | Target offset register address |
| wr_data | output | 8 | Trim value to write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| ofs_x | output | 8 | Last computed X trim |
| ofs_y | output | 8 | Last computed Y trim |
| ofs_z | output | 8 | Last computed Z trim |

## Verification
The bench shortens `SETTLE_CYCLES` to 40 so that many runs fit in the budget, and it keeps `NUM_SAMPLES` at its default of 100. This means the real divide-by-count path is exercised, including truncation toward zero on negative sums. It also keeps the default 13-bit sample width and Z bias of 345. With these values, the directed means of ±4000 drive both clamp limits, and means of ±5 and ±3 probe rounding on the divide-by-4 step. Full-scale junk samples sent during the shortened settle window would visibly move the means if they were counted. Acknowledge delays of 0 to 3 cycles stretch the handshake.

// File: rtl/acal_pkg.sv
package acal_pkg;

    localparam int OFS_W  = 8;
    localparam int ADDR_W = 8;
    localparam int N_AXES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GATHER,
        ST_SOLVE,
        ST_WRITE,
        ST_DONE
    } cal_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [OFS_W-1:0]  data;
    } wr_beat_t;

    // Divide by four, rounding toward zero.
    function automatic logic signed [31:0] quarter_tz(input logic signed [31:0] v);
        logic signed [31:0] biased;
        biased = v[31] ? (v + 32'sd3) : v;
        return biased >>> 2;
    endfunction

    // Clamp to the signed 8-bit trim range.
    function automatic logic [OFS_W-1:0] sat_ofs(input logic signed [31:0] v);
        logic [OFS_W-1:0] r;
        if (v > 32'sd127)
            r = 8'h7F;
        else if (v < -32'sd128)
            r = 8'h80;
        else
            r = v[OFS_W-1:0];
        return r;
    endfunction

    function automatic logic [OFS_W-1:0] axis_trim(input logic signed [31:0] mean,
                                                   input logic signed [31:0] bias);
        return sat_ofs(-quarter_tz(mean - bias));
    endfunction

endpackage

// File: rtl/acal_ctrl.sv
module acal_ctrl
    import acal_pkg::*;
#(
    parameter int SETTLE_CYCLES = 555000,
    parameter int NUM_SAMPLES   = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       smp_valid,
    input  logic       last_ack,
    output cal_state_e state_o,
    output logic       clear_acc,
    output logic       gather_add
);

    localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
    localparam int CNT_W = $clog2(NUM_SAMPLES + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_SAMPLES - 1);

    cal_state_e       state_q, state_d;
    logic [SET_W-1:0] set_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETTLE;
            ST_SETTLE: if (set_q == SET_LAST) state_d = ST_GATHER;
            ST_GATHER: if (smp_valid && (cnt_q == CNT_LAST)) state_d = ST_SOLVE;
            ST_SOLVE:  state_d = ST_WRITE;
            ST_WRITE:  if (last_ack) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            set_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE)
                set_q <= set_q + 1'b1;
            else
                set_q <= '0;
            if (state_q == ST_GATHER) begin
                if (smp_valid)
                    cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign clear_acc  = (state_q == ST_IDLE) && start;
    assign gather_add = (state_q == ST_GATHER) && smp_valid;
    assign state_o    = state_q;

endmodule

// File: rtl/acal_accum.sv
module acal_accum
    import acal_pkg::*;
#(
    parameter int SAMPLE_W = 13,
    parameter int SUM_W    = 21
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               clear,
    input  logic                               add,
    input  logic [N_AXES-1:0][SAMPLE_W-1:0]    smp_i,
    output logic [N_AXES-1:0][SUM_W-1:0]       sum_o
);

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        logic [SUM_W-1:0] acc_q;
        logic [SUM_W-1:0] ext;

        assign ext = {{(SUM_W - SAMPLE_W){smp_i[a][SAMPLE_W-1]}}, smp_i[a]};

        always_ff @(posedge clk) begin
            if (rst || clear)
                acc_q <= '0;
            else if (add)
                acc_q <= acc_q + ext;
        end

        assign sum_o[a] = acc_q;
    end

endmodule

// File: rtl/acal_corr.sv
module acal_corr
    import acal_pkg::*;
#(
    parameter int SUM_W       = 21,
    parameter int NUM_SAMPLES = 100,
    parameter int Z_BIAS      = 345
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic [N_AXES-1:0][SUM_W-1:0]   sum_i,
    output logic [N_AXES-1:0][OFS_W-1:0]   ofs_o
);

    localparam logic signed [31:0] DIVISOR = 32'(NUM_SAMPLES);

    for (genvar a = 0; a < N_AXES; a++) begin : g_axis
        // Only the last axis carries the 1 g reading.
        localparam logic signed [31:0] BIAS = (a == N_AXES - 1) ? 32'(Z_BIAS) : 32'sd0;

        logic signed [31:0] sum_s;
        logic signed [31:0] mean_s;
        logic [OFS_W-1:0]   trim_q;

        assign sum_s  = {{(32 - SUM_W){sum_i[a][SUM_W-1]}}, sum_i[a]};
        assign mean_s = sum_s / DIVISOR;

        always_ff @(posedge clk) begin
            if (rst)
                trim_q <= '0;
            else if (load)
                trim_q <= axis_trim(mean_s, BIAS);
        end

        assign ofs_o[a] = trim_q;
    end

endmodule

// File: rtl/acal_wr.sv
module acal_wr
    import acal_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_X = 8'h1E,
    parameter logic [ADDR_W-1:0] ADDR_Y = 8'h1F,
    parameter logic [ADDR_W-1:0] ADDR_Z = 8'h20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          active,
    input  logic                          wr_ack,
    input  logic [N_AXES-1:0][OFS_W-1:0]  ofs_i,
    output logic                          wr_req,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [OFS_W-1:0]              wr_data,
    output logic                          last_ack
);

    localparam int IDX_W = $clog2(N_AXES + 1);
    localparam logic [ADDR_W-1:0] ADDRS [N_AXES] = '{ADDR_X, ADDR_Y, ADDR_Z};

    wr_beat_t         beats [N_AXES];
    wr_beat_t         cur;
    logic [IDX_W-1:0] idx_q;
    logic             req_q;

    for (genvar a = 0; a < N_AXES; a++) begin : g_beat
        assign beats[a] = '{addr: ADDRS[a], data: ofs_i[a]};
    end

    always_comb begin
        cur = beats[0];
        for (int a = 0; a < N_AXES; a++) begin
            if (idx_q == IDX_W'(a))
                cur = beats[a];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            idx_q <= '0;
            req_q <= 1'b0;
        end else if (req_q && wr_ack) begin
            req_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end else if (!req_q && (idx_q < IDX_W'(N_AXES))) begin
            req_q <= 1'b1;
        end
    end

    assign wr_req   = req_q;
    assign wr_addr  = cur.addr;
    assign wr_data  = cur.data;
    assign last_ack = req_q && wr_ack && (idx_q == IDX_W'(N_AXES - 1));

endmodule

// File: rtl/acal_engine.sv
module acal_engine
    import acal_pkg::*;
#(
    parameter int                SAMPLE_W      = 13,
    parameter int                SETTLE_CYCLES = 555000,
    parameter int                NUM_SAMPLES   = 100,
    parameter int                Z_BIAS        = 345,
    parameter logic [ADDR_W-1:0] ADDR_X        = 8'h1E,
    parameter logic [ADDR_W-1:0] ADDR_Y        = 8'h1F,
    parameter logic [ADDR_W-1:0] ADDR_Z        = 8'h20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_y,
    input  logic [SAMPLE_W-1:0] smp_z,
    input  logic                wr_ack,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [OFS_W-1:0]    wr_data,
    output logic                busy,
    output logic                done,
    output logic [OFS_W-1:0]    ofs_x,
    output logic [OFS_W-1:0]    ofs_y,
    output logic [OFS_W-1:0]    ofs_z
);

    localparam int SUM_W = SAMPLE_W + $clog2(NUM_SAMPLES) + 1;

    cal_state_e                      state;
    logic                            clear_acc;
    logic                            gather_add;
    logic                            last_ack;
    logic [N_AXES-1:0][SAMPLE_W-1:0] smp_vec;
    logic [N_AXES-1:0][SUM_W-1:0]    sums;
    logic [N_AXES-1:0][OFS_W-1:0]    trims;

    assign smp_vec = {smp_z, smp_y, smp_x};

    acal_ctrl #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .NUM_SAMPLES   (NUM_SAMPLES)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .smp_valid  (smp_valid),
        .last_ack   (last_ack),
        .state_o    (state),
        .clear_acc  (clear_acc),
        .gather_add (gather_add)
    );

    acal_accum #(
        .SAMPLE_W (SAMPLE_W),
        .SUM_W    (SUM_W)
    ) u_accum (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_acc),
        .add   (gather_add),
        .smp_i (smp_vec),
        .sum_o (sums)
    );

    acal_corr #(
        .SUM_W       (SUM_W),
        .NUM_SAMPLES (NUM_SAMPLES),
        .Z_BIAS      (Z_BIAS)
    ) u_corr (
        .clk   (clk),
        .rst   (rst),
        .load  (state == ST_SOLVE),
        .sum_i (sums),
        .ofs_o (trims)
    );

    acal_wr #(
        .ADDR_X (ADDR_X),
        .ADDR_Y (ADDR_Y),
        .ADDR_Z (ADDR_Z)
    ) u_wr (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_WRITE),
        .wr_ack   (wr_ack),
        .ofs_i    (trims),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .last_ack (last_ack)
    );

    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);
    assign ofs_x = trims[0];
    assign ofs_y = trims[1];
    assign ofs_z = trims[2];

endmodule

// File: rtl/acal_engine_chk.sv
module acal_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       wr_req,
    input logic       wr_ack,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       done
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_req && !done)); // R1

    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R8

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ack) |=> !wr_req); // R8

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R10

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_req && wr_ack)); // R10

endmodule

bind acal_engine acal_engine_chk u_chk (.*);

// File: tb/acal_engine_bench.sv
module acal_engine_bench;

    localparam int SW  = 13;
    localparam int SET = 40;
    localparam int NS  = 100;
    localparam int ZB  = 345;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic          wr_ack = 1'b0;
    logic          wr_req, busy, done;
    logic [7:0]    wr_addr, wr_data, ofs_x, ofs_y, ofs_z;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acal_engine #(
        .SAMPLE_W      (SW),
        .SETTLE_CYCLES (SET),
        .NUM_SAMPLES   (NS),
        .Z_BIAS        (ZB)
    ) u_acal_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .smp_valid (smp_valid),
        .smp_x     (smp_x),
        .smp_y     (smp_y),
        .smp_z     (smp_z),
        .wr_ack    (wr_ack),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done),
        .ofs_x     (ofs_x),
        .ofs_y     (ofs_y),
        .ofs_z     (ofs_z)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int s8(input logic [7:0] v);
        return int'($signed(v));
    endfunction

    function automatic int exp_trim(input int sum, input int bias);
        int mean, q, c;
        mean = sum / NS;
        q    = (mean - bias) / 4;
        c    = -q;
        if (c > 127)  c = 127;
        if (c < -128) c = -128;
        return c;
    endfunction

    function automatic int clamp13(input int v);
        if (v > 4095)  return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    // One full run. Junk is driven during settling; poke re-pulses start mid-run.
    task automatic run_cal(input int bx, input int by, input int bz, input int nz,
                           input bit poke, output int tx, output int ty, output int tz);
        int sx = 0, sy = 0, sz = 0;
        int ea [3];
        logic [7:0] addr_exp [3];
        addr_exp = '{8'h1E, 8'h1F, 8'h20};

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);

        for (int i = 0; i < SET - 3; i++) begin
            smp_valid = 1'b1;
            smp_x = 13'h0FFF; smp_y = 13'h1000; smp_z = 13'h0FFF;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (6) @(negedge clk);

        for (int i = 0; i < NS; i++) begin
            int vx, vy, vz;
            vx = clamp13(bx + int'($urandom_range(0, 2 * nz)) - nz);
            vy = clamp13(by + int'($urandom_range(0, 2 * nz)) - nz);
            vz = clamp13(bz + int'($urandom_range(0, 2 * nz)) - nz);
            sx += vx; sy += vy; sz += vz;
            smp_valid = 1'b1;
            smp_x = SW'(vx); smp_y = SW'(vy); smp_z = SW'(vz);
            if (poke && i == NS / 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            smp_valid = 1'b0;
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        smp_valid = 1'b0;

        ea[0] = exp_trim(sx, 0);
        ea[1] = exp_trim(sy, 0);
        ea[2] = exp_trim(sz, ZB);
        tx = ea[0]; ty = ea[1]; tz = ea[2];

        for (int k = 0; k < 3; k++) begin
            int d;
            logic [7:0] a0, d0;
            while (!wr_req) @(negedge clk);
            chk(wr_addr == addr_exp[k], "R7 write address", int'(wr_addr), int'(addr_exp[k]));
            if (k == 2)
                chk(s8(wr_data) == ea[k], "R5 Z trim", s8(wr_data), ea[k]);
            else
                chk(s8(wr_data) == ea[k], "R4 X/Y trim", s8(wr_data), ea[k]);
            a0 = wr_addr; d0 = wr_data;
            d = int'($urandom_range(0, 3));
            for (int w = 0; w < d; w++) begin
                @(negedge clk);
                chk(wr_req && wr_addr == a0 && wr_data == d0, "R8 hold until ack",
                    int'(wr_req), 1);
            end
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack = 1'b0;
            chk(wr_req == 1'b0, "R8 request drops after ack", int'(wr_req), 0);
            if (k == 2) begin
                chk(done == 1'b1, "R10 done after last ack", int'(done), 1);
                @(negedge clk);
                chk(done == 1'b0 && busy == 1'b0, "R10 single pulse then idle",
                    int'(done) + int'(busy), 0);
            end
        end

        chk(s8(ofs_x) == ea[0] && s8(ofs_y) == ea[1] && s8(ofs_z) == ea[2],
            "R3 trim outputs", s8(ofs_x), ea[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int tx, ty, tz;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !wr_req && !done, "R1 control low after reset",
            int'(busy) + int'(wr_req) + int'(done), 0);
        chk(ofs_x == 0 && ofs_y == 0 && ofs_z == 0, "R1 trims zero after reset",
            int'(ofs_x) + int'(ofs_y) + int'(ofs_z), 0);

        // Zero input: junk during settling must not count; Z removes bias.
        run_cal(0, 0, 0, 0, 1'b0, tx, ty, tz);
        chk(s8(ofs_x) == 0, "R2 settle samples discarded", s8(ofs_x), 0);
        chk(s8(ofs_z) == 86, "R5 Z zero mean", s8(ofs_z), 86);

        // Clamping at both limits.
        run_cal(4000, -4000, ZB, 0, 1'b0, tx, ty, tz);
        chk(ofs_x == 8'h80, "R6 negative clamp", s8(ofs_x), -128);
        chk(ofs_y == 8'h7F, "R6 positive clamp", s8(ofs_y), 127);
        chk(s8(ofs_z) == 0, "R5 Z at 1 g", s8(ofs_z), 0);

        // Rounding toward zero on the quarter step.
        run_cal(-5, 5, 350, 0, 1'b0, tx, ty, tz);
        chk(s8(ofs_x) == 1 && s8(ofs_y) == -1, "R4 rounding of +/-5", s8(ofs_x), 1);
        run_cal(-3, 3, 342, 0, 1'b0, tx, ty, tz);
        chk(s8(ofs_x) == 0 && s8(ofs_y) == 0 && s8(ofs_z) == 0, "R4 rounding of +/-3",
            s8(ofs_x), 0);

        // Mean truncation toward zero with noisy negative sums.
        run_cal(-1, 1, 0, 3, 1'b0, tx, ty, tz);

        // Start pulse during a run is ignored.
        run_cal(120, -77, 300, 40, 1'b1, tx, ty, tz);
        repeat (5) @(negedge clk);
        chk(!busy && !wr_req, "R9 no restart from mid-run start",
            int'(busy) + int'(wr_req), 0);

        for (int r = 0; r < 6; r++) begin
            int bx, by, bz;
            bx = int'($urandom_range(0, 1200)) - 600;
            by = int'($urandom_range(0, 1200)) - 600;
            bz = int'($urandom_range(0, 1400)) - 355;
            run_cal(bx, by, bz, int'($urandom_range(0, 60)), r[0], tx, ty, tz);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule